// File: doc/BRIEF.md
# Sequential Floating-Point Adder/Subtractor

This block adds or subtracts two floating-point operands over several clock cycles. Each operand has three parts: a sign bit, a magnitude that is a pure fraction with the binary point to the left of its top bit, and an exponent field. The exponent field is stored with a bias of 2^(EW-1)-1 and is handled throughout as an unsigned number, so it has no sign of its own. Subtraction flips the sign of the second operand and then adds in sign-magnitude form.

The unit first checks whether either magnitude is zero. If so, it returns the other operand at once. Otherwise a comparator with three outputs (greater, less, equal) drives the alignment step. Each cycle, the mantissa with the smaller exponent moves right by one bit and its exponent goes up by one, until the two exponents match. Bits shifted out are dropped. One parallel adder then combines the two magnitudes and keeps its carry-out as a separate bit. If there is a carry, a single right shift with exponent increment corrects the result. If the top bit of the result is zero, the unit shifts left one bit per cycle and decrements the exponent until that bit is set. The exponent is never checked for overflow or underflow: it wraps modulo 2^EW.

The operand interface follows a valid/ready rule. `start` acts as valid and `ready` shows that the unit is idle. An operand pair is taken only on a clock edge where both are high. The result side has no back-pressure: `done` is high for exactly one cycle, and the result pins then hold their value until the next result is produced.

Top module: `fpas_top`

## Requirements
- R1: After reset, `ready` is 1, `done` is 0, and the result pins are all zero.
- R2: A start is taken only when `ready` is 1. `ready` stays 0 from that edge until `done`. A `start` raised while busy has no effect on the result. `done` lasts one cycle, `ready` returns in the next cycle, and the result pins stay constant while idle.
- R3: When `op_sub` is 1, the sign of operand B is inverted before the sign-magnitude addition.
- R4: An operand counts as zero when its magnitude is all zeros, whatever its exponent. If B is zero, the result is A, or +0 when A is zero too. If only A is zero, the result is B with its effective sign. `done` rises on the cycle after the accepting edge.
- R5: Exponents are compared as unsigned numbers. Each cycle of alignment shifts the mantissa with the smaller exponent right by one and increments that exponent. Shifted-out bits are truncated.
- R6: With equal effective signs, the magnitudes are added. On a carry-out, the magnitude becomes {1, sum[MW-1:1]} and the exponent rises by one modulo 2^EW, with no overflow indication.
- R7: With different effective signs, the smaller aligned magnitude is subtracted from the larger, and the result takes the sign of the larger.
- R8: An exact zero sum is returned as sign 0, magnitude 0, exponent 0, with no normalization.
- R9: A nonzero result whose top magnitude bit is 0 is shifted left one bit per cycle, with the exponent decremented modulo 2^EW each time, until bit MW-1 is 1.
- R10: For nonzero operands, the number of edges from the accepting edge to the cycle showing `done` is 3 + |ea-eb|, plus k+1 when k ≥ 1 left shifts are needed. Zero bypass takes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operand pair valid |
| ready | output | 1 | Idle, able to accept an operand pair |
| op_sub | input | 1 | 1 = subtract B from A, 0 = add |
| a_sign | input | 1 | Sign of A (1 = negative) |
| a_mant | input | MW | Fractional magnitude of A |
| a_exp | input | EW | Biased exponent of A |
| b_sign | input | 1 | Sign of B |
| b_mant | input | MW | Fractional magnitude of B |
| b_exp | input | EW | Biased exponent of B |
| done | output | 1 | One-cycle pulse, result valid |
| res_sign | output | 1 | Result sign |
| res_mant | output | MW | Result magnitude |
| res_exp | output | EW | Result biased exponent |

## Verification
Two functions can act in the same adder step: the carry-out correction shift and the ignored exponent wrap. The bench triggers both by adding two operands whose exponents are all ones and whose magnitudes both have the top bit set. It checks that the magnitude arrives shifted right with a leading one and that the exponent wraps to zero. Normalization can also wrap the exponent below zero, and a directed case checks that as well. Every result and its cycle count are compared against a bench model that aligns in one step and normalizes in a loop.

// File: rtl/fpas_pkg.sv
package fpas_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_ADD,
    ST_NORM,
    ST_FIN
  } fpas_state_t;
endpackage

// File: rtl/fpas_expcmp.sv
module fpas_expcmp #(
  parameter int EW = 6
) (
  input  logic [EW-1:0] x,
  input  logic [EW-1:0] y,
  output logic          gt,
  output logic          lt,
  output logic          eq
);
  // unsigned compare: biased exponents carry no sign
  always_comb begin
    gt = (x > y);
    lt = (x < y);
    eq = (x == y);
  end
endmodule

// File: rtl/fpas_magadd.sv
module fpas_magadd #(
  parameter int MW = 8
) (
  input  logic          s_x,
  input  logic [MW-1:0] m_x,
  input  logic          s_y,
  input  logic [MW-1:0] m_y,
  output logic [MW-1:0] sum,
  output logic          carry,
  output logic          sgn
);
  logic [MW:0] wide;

  always_comb begin
    wide  = '0;
    carry = 1'b0;
    sgn   = s_x;
    if (s_x == s_y) begin
      wide  = {1'b0, m_x} + {1'b0, m_y};
      carry = wide[MW];
    end else if (m_x >= m_y) begin
      wide = {1'b0, m_x - m_y};
    end else begin
      wide = {1'b0, m_y - m_x};
      sgn  = s_y;
    end
    sum = wide[MW-1:0];
  end
endmodule

// File: rtl/fpas_top.sv
module fpas_top #(
  parameter int MW = 8,
  parameter int EW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          ready,
  input  logic          op_sub,
  input  logic          a_sign,
  input  logic [MW-1:0] a_mant,
  input  logic [EW-1:0] a_exp,
  input  logic          b_sign,
  input  logic [MW-1:0] b_mant,
  input  logic [EW-1:0] b_exp,
  output logic          done,
  output logic          res_sign,
  output logic [MW-1:0] res_mant,
  output logic [EW-1:0] res_exp
);
  import fpas_pkg::*;

  localparam logic [EW-1:0] EXP_ONE = EW'(1);

  fpas_state_t   st;
  logic          xa_s, xb_s, w_s;
  logic [MW-1:0] xa_m, xb_m, w_m;
  logic [EW-1:0] xa_e, xb_e, w_e;
  logic          cmp_gt, cmp_lt, cmp_eq;
  logic [MW-1:0] add_sum;
  logic          add_c, add_s;

  fpas_expcmp #(.EW(EW)) u_cmp (
    .x (xa_e), .y (xb_e),
    .gt(cmp_gt), .lt(cmp_lt), .eq(cmp_eq)
  );

  fpas_magadd #(.MW(MW)) u_add (
    .s_x(xa_s), .m_x(xa_m), .s_y(xb_s), .m_y(xb_m),
    .sum(add_sum), .carry(add_c), .sgn(add_s)
  );

  assign ready = (st == ST_IDLE);
  assign done  = (st == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      xa_s     <= 1'b0; xa_m <= '0; xa_e <= '0;
      xb_s     <= 1'b0; xb_m <= '0; xb_e <= '0;
      w_s      <= 1'b0; w_m  <= '0; w_e  <= '0;
      res_sign <= 1'b0; res_mant <= '0; res_exp <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          xa_s <= a_sign;          xa_m <= a_mant; xa_e <= a_exp;
          xb_s <= b_sign ^ op_sub; xb_m <= b_mant; xb_e <= b_exp;
          if (b_mant == '0) begin
            st <= ST_FIN;
            if (a_mant == '0) begin
              res_sign <= 1'b0; res_mant <= '0; res_exp <= '0;
            end else begin
              res_sign <= a_sign; res_mant <= a_mant; res_exp <= a_exp;
            end
          end else if (a_mant == '0) begin
            st       <= ST_FIN;
            res_sign <= b_sign ^ op_sub;
            res_mant <= b_mant;
            res_exp  <= b_exp;
          end else begin
            st <= ST_ALIGN;
          end
        end
        ST_ALIGN: begin
          if (cmp_gt) begin
            xb_m <= xb_m >> 1;
            xb_e <= xb_e + EXP_ONE;
          end else if (cmp_lt) begin
            xa_m <= xa_m >> 1;
            xa_e <= xa_e + EXP_ONE;
          end else if (cmp_eq) begin
            st <= ST_ADD;
          end
        end
        ST_ADD: begin
          if (add_c) begin
            res_sign <= add_s;
            res_mant <= {1'b1, add_sum[MW-1:1]};
            res_exp  <= xa_e + EXP_ONE;
            st       <= ST_FIN;
          end else if (add_sum == '0) begin
            res_sign <= 1'b0; res_mant <= '0; res_exp <= '0;
            st       <= ST_FIN;
          end else if (add_sum[MW-1]) begin
            res_sign <= add_s; res_mant <= add_sum; res_exp <= xa_e;
            st       <= ST_FIN;
          end else begin
            w_s <= add_s; w_m <= add_sum; w_e <= xa_e;
            st  <= ST_NORM;
          end
        end
        ST_NORM: begin
          if (w_m[MW-1]) begin
            res_sign <= w_s; res_mant <= w_m; res_exp <= w_e;
            st       <= ST_FIN;
          end else begin
            w_m <= w_m << 1;
            w_e <= w_e - EXP_ONE;
          end
        end
        ST_FIN:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpas_chk.sv
module fpas_chk #(
  parameter int MW = 8,
  parameter int EW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          ready,
  input logic          done,
  input logic          res_sign,
  input logic [MW-1:0] res_mant,
  input logic [EW-1:0] res_exp
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready); // R2
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ready); // R2
  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !done); // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> (done || $stable({res_sign, res_mant, res_exp}))); // R2
  AST_ZERO_CANONICAL: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_mant == '0) |-> (!res_sign && res_exp == '0)); // R8
endmodule

bind fpas_top fpas_chk #(.MW(MW), .EW(EW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .done(done),
  .res_sign(res_sign), .res_mant(res_mant), .res_exp(res_exp)
);

// File: tb/fpas_top_tb_top.sv
module fpas_top_tb_top;
  localparam int MW = 8;
  localparam int EW = 6;

  typedef struct packed {
    logic          s;
    logic [MW-1:0] m;
    logic [EW-1:0] e;
    logic [15:0]   lat;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, op_sub = 1'b0;
  logic a_sign = 1'b0, b_sign = 1'b0;
  logic [MW-1:0] a_mant = '0, b_mant = '0;
  logic [EW-1:0] a_exp = '0, b_exp = '0;
  logic ready, done, res_sign;
  logic [MW-1:0] res_mant;
  logic [EW-1:0] res_exp;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  fpas_top #(.MW(MW), .EW(EW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .ready(ready), .op_sub(op_sub),
    .a_sign(a_sign), .a_mant(a_mant), .a_exp(a_exp),
    .b_sign(b_sign), .b_mant(b_mant), .b_exp(b_exp),
    .done(done), .res_sign(res_sign), .res_mant(res_mant), .res_exp(res_exp)
  );

  function automatic exp_t model(input logic sa, input logic [MW-1:0] ma,
      input logic [EW-1:0] ea, input logic sb, input logic [MW-1:0] mb,
      input logic [EW-1:0] eb, input logic sub);
    exp_t r;
    logic sbe;
    logic [MW:0] w;
    int d, k;
    sbe = sb ^ sub;
    r = '0;
    r.lat = 16'd1;
    if (mb == '0) begin
      if (ma != '0) begin r.s = sa; r.m = ma; r.e = ea; end
      return r;
    end
    if (ma == '0) begin r.s = sbe; r.m = mb; r.e = eb; return r; end
    if (ea >= eb) begin d = int'(ea) - int'(eb); mb = mb >> d; r.e = ea; end
    else begin d = int'(eb) - int'(ea); ma = ma >> d; r.e = eb; end
    r.lat = 16'(3 + d);
    if (sa == sbe) begin
      w = {1'b0, ma} + {1'b0, mb};
      r.s = sa;
      if (w[MW]) begin
        r.m = w[MW:1];
        r.e = r.e + 1'b1;
        return r;
      end
      r.m = w[MW-1:0];
    end else if (ma >= mb) begin
      r.m = ma - mb; r.s = sa;
    end else begin
      r.m = mb - ma; r.s = sbe;
    end
    if (r.m == '0) begin r.s = 1'b0; r.e = '0; return r; end
    k = 0;
    while (!r.m[MW-1]) begin r.m = r.m << 1; r.e = r.e - 1'b1; k++; end
    if (k > 0) r.lat = r.lat + 16'(k + 1);
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic run(input logic sa, input logic [MW-1:0] ma, input logic [EW-1:0] ea,
      input logic sb, input logic [MW-1:0] mb, input logic [EW-1:0] eb,
      input logic sub, input string req, input bit poke);
    exp_t x;
    int lat;
    x = model(sa, ma, ea, sb, mb, eb, sub);
    check(ready === 1'b1, "R2", "ready before start", longint'(ready), 1);
    a_sign = sa; a_mant = ma; a_exp = ea;
    b_sign = sb; b_mant = mb; b_exp = eb; op_sub = sub; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a_mant = ~ma; b_mant = ~mb; a_exp = ~ea; op_sub = ~sub;
    lat = 1;
    while (done !== 1'b1 && lat < 2000) begin
      start = 1'b0;
      if (poke && lat == 2) begin
        check(ready === 1'b0, "R2", "ready while busy", longint'(ready), 0);
        start = 1'b1;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(lat < 2000, "R2", "done timeout", lat, 0);
    check({res_sign, res_mant, res_exp} === {x.s, x.m, x.e}, req, "result",
          longint'({res_sign, res_mant, res_exp}), longint'({x.s, x.m, x.e}));
    check(lat == int'(x.lat), "R10", "latency", lat, longint'(x.lat));
    @(negedge clk);
    check(done === 1'b0 && ready === 1'b1, "R2", "done/ready after pulse",
          longint'({done, ready}), 1);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready === 1'b1 && done === 1'b0, "R1", "idle after reset",
          longint'({ready, done}), 2);
    check({res_sign, res_mant, res_exp} === '0, "R1", "result after reset",
          longint'({res_sign, res_mant, res_exp}), 0);
    // zero bypass cases
    run(1'b1, 8'h00, 6'd0, 1'b0, 8'h00, 6'd0, 1'b1, "R4", 1'b0);
    run(1'b0, 8'h00, 6'd7, 1'b0, 8'hA5, 6'd40, 1'b1, "R4", 1'b0);
    run(1'b1, 8'h91, 6'd12, 1'b1, 8'h00, 6'd33, 1'b0, "R4", 1'b0);
    // cancellation gives canonical +0
    run(1'b1, 8'hB3, 6'd20, 1'b1, 8'hB3, 6'd20, 1'b1, "R8", 1'b0);
    // carry correction coinciding with exponent wrap
    run(1'b0, 8'hC0, 6'd63, 1'b0, 8'hC0, 6'd63, 1'b0, "R6", 1'b0);
    // normalization below zero exponent wraps
    run(1'b0, 8'h80, 6'd0, 1'b0, 8'h7F, 6'd0, 1'b1, "R9", 1'b0);
    // widest alignment, smaller operand shifted away
    run(1'b0, 8'h81, 6'd63, 1'b1, 8'hFF, 6'd0, 1'b0, "R5", 1'b0);
    run(1'b1, 8'h90, 6'd2, 1'b0, 8'hF0, 6'd5, 1'b0, "R5", 1'b0);
    // sign of larger magnitude, subtraction flips B
    run(1'b0, 8'h90, 6'd9, 1'b0, 8'hE0, 6'd9, 1'b1, "R7", 1'b0);
    run(1'b1, 8'hA0, 6'd9, 1'b1, 8'h90, 6'd9, 1'b1, "R3", 1'b0);
    // start while busy is ignored
    run(1'b0, 8'hC4, 6'd30, 1'b1, 8'h88, 6'd20, 1'b0, "R2", 1'b1);
    for (int i = 0; i < 400; i++) begin
      logic [MW-1:0] ma, mb;
      logic [EW-1:0] ea, eb;
      ma = MW'($urandom);
      mb = MW'($urandom);
      if (($urandom % 4) != 0) ma[MW-1] = 1'b1;
      if (($urandom % 4) != 0) mb[MW-1] = 1'b1;
      if (($urandom % 25) == 0) ma = '0;
      if (($urandom % 25) == 0) mb = '0;
      ea = EW'($urandom);
      eb = (($urandom % 2) == 0) ? ea ^ EW'($urandom % 4) : EW'($urandom);
      if (($urandom % 8) == 0) mb = ma;
      run(1'($urandom), ma, ea, 1'($urandom), mb, eb, 1'($urandom),
          "R6/R7 random", 1'b0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule